// File: doc/BRIEF.md
# Calendar Real-Time Clock with Field-Selective Alarm

This block keeps wall-clock time and date: second, minute, hour, weekday, day of month, month and a 12-bit year. A programmable divider turns a reference clock into a once-per-second advance. The advance ripples through cascaded counters, which know the length of each month and the leap-year rule. Software uses a simple register read/write port for four things: preload a date and time, start and stop counting, read the live calendar, and program an alarm.

The alarm compares the live calendar with target values. Only the fields that software has selected take part, and a global enable arms the comparison. The comparison result is the raw interrupt. The raw interrupt is level-sensitive: it stays high for as long as the selected fields keep matching. The interrupt pin combines the raw level with an enable, and a force bit can drive it on its own. Software can read the raw, enable, force and resulting status values at separate addresses.

Top module: `rtcal_top`

## Requirements
- R1: The divider register (address 0, bits [15:0]) holds the divide ratio minus one, D. When counting is started from stop, the seconds advance on reference edge 1+k*(D+1) (k>=1), counting edges from the one after the enable write.
- R2: Second and minute wrap from 59 to 0 and hour wraps from 23 to 0. Each wrap carries one step into the next field up.
- R3: A carry out of the hour advances weekday (7 wraps to 1, 1 is Monday) and day of month. Day of month wraps from the month length to 1 (30 days for months 4, 6, 9 and 11, 31 for the others, February per R4/R5). Month wraps from 12 to 1 and then increments the year.
- R4: February has 29 days when the year is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28.
- R5: While the no-leap bit (control address 1, bit 3) is set, February always has 28 days.
- R6: Writing control with bit 2 set copies the setup date (address 2) and setup time (address 3) into the live counters (date at address 4, time at address 5) on that edge. Bit 2 reads back as 0. The date layout is year [23:12], month [11:8], day [4:0]. The time layout is weekday [26:24], hour [20:16], minute [13:8], second [5:0].
- R7: Control bit 0 is the run enable. Control bit 1 is a read-only running flag that follows the enable one cycle later. While the block is stopped, the live time does not change.
- R8: Alarm configuration is at address 6. Bit 0 is the global enable and bit 1 is a read-only armed flag. Bits 2..8 select second, minute, hour, weekday, day, month and year. Alarm targets are at address 7 (date layout) and address 8 (time layout). Only the selected fields are compared, and nothing matches while the block is disarmed.
- R9: The raw interrupt (address 9, bit 0) is high exactly while the armed alarm matches. It falls once the calendar moves past the target.
- R10: irq equals (raw AND enable) OR force. The enable is at address 10 bit 0, the force at address 11 bit 0, and the resulting status reads at address 12 bit 0.
- R11: After reset the live date and time, the control register, the interrupt status and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq | output | 1 | Masked and forced interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit divider, 4-bit addresses, 32-bit data and a registered raw interrupt. It programs the divide ratio to 1 for single-second stepping and to 4 for the timing check. The block can stop after exactly one second, so every rollover can be reached by preloading the time just before it. This makes room for full sweeps: all 60 seconds and all 24 hours at a carry boundary, every month end in a common and a leap year, and every February of all 4096 years, both with and without the no-leap override.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

   typedef struct packed {
      logic [11:0] year;
      logic [3:0]  month;
      logic [4:0]  day;
   } date_t;

   typedef struct packed {
      logic [2:0] dow;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } time_t;

   localparam int A_DIV       = 0;
   localparam int A_CTRL      = 1;
   localparam int A_SET_DATE  = 2;
   localparam int A_SET_TIME  = 3;
   localparam int A_NOW_DATE  = 4;
   localparam int A_NOW_TIME  = 5;
   localparam int A_ALM_CFG   = 6;
   localparam int A_ALM_DATE  = 7;
   localparam int A_ALM_TIME  = 8;
   localparam int A_IRQ_RAW   = 9;
   localparam int A_IRQ_EN    = 10;
   localparam int A_IRQ_FORCE = 11;
   localparam int A_IRQ_STAT  = 12;

   localparam int NUM_FIELDS = 7;

   function automatic logic [31:0] pack_date(input date_t d);
      logic [31:0] w;
      w = '0;
      w[23:12] = d.year;
      w[11:8]  = d.month;
      w[4:0]   = d.day;
      return w;
   endfunction

   function automatic date_t unpack_date(input logic [31:0] w);
      date_t d;
      d.year  = w[23:12];
      d.month = w[11:8];
      d.day   = w[4:0];
      return d;
   endfunction

   function automatic logic [31:0] pack_time(input time_t t);
      logic [31:0] w;
      w = '0;
      w[26:24] = t.dow;
      w[20:16] = t.hour;
      w[13:8]  = t.min;
      w[5:0]   = t.sec;
      return w;
   endfunction

   function automatic time_t unpack_time(input logic [31:0] w);
      time_t t;
      t.dow  = w[26:24];
      t.hour = w[20:16];
      t.min  = w[13:8];
      t.sec  = w[5:0];
      return t;
   endfunction

   function automatic logic leap_year(input logic [11:0] y, input logic no_leap);
      int unsigned v;
      v = int'(y);
      return !no_leap && ((v % 4) == 0) && (((v % 100) != 0) || ((v % 400) == 0));
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
      case (m)
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         4'd2:                    return leap ? 5'd29 : 5'd28;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtcal_divider.sv
module rtcal_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt >= limit);
   assign tick   = run && !clear && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || clear)       cnt <= '0;
      else if (at_end)              cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rtcal_calendar.sv
module rtcal_calendar
   import rtcal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  load,
   input  logic  no_leap,
   input  date_t set_date,
   input  time_t set_time,
   output date_t now_date,
   output time_t now_time
);
   logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
   logic       min_adv, hour_adv, day_adv;
   logic [4:0] cur_len;

   assign cur_len   = month_len(now_date.month, leap_year(now_date.year, no_leap));
   assign sec_wrap  = (now_time.sec  >= 6'd59);
   assign min_wrap  = (now_time.min  >= 6'd59);
   assign hour_wrap = (now_time.hour >= 5'd23);
   assign day_wrap  = (now_date.day  >= cur_len);
   assign mon_wrap  = (now_date.month >= 4'd12);
   assign min_adv   = sec_wrap;
   assign hour_adv  = min_adv && min_wrap;
   assign day_adv   = hour_adv && hour_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_date <= '0;
         now_time <= '0;
      end else if (load) begin
         now_date <= set_date;
         now_time <= set_time;
      end else if (tick) begin
         now_time.sec <= sec_wrap ? 6'd0 : now_time.sec + 6'd1;
         if (min_adv)
            now_time.min <= min_wrap ? 6'd0 : now_time.min + 6'd1;
         if (hour_adv)
            now_time.hour <= hour_wrap ? 5'd0 : now_time.hour + 5'd1;
         if (day_adv) begin
            now_time.dow <= (now_time.dow >= 3'd7) ? 3'd1 : now_time.dow + 3'd1;
            now_date.day <= day_wrap ? 5'd1 : now_date.day + 5'd1;
            if (day_wrap)
               now_date.month <= mon_wrap ? 4'd1 : now_date.month + 4'd1;
            if (day_wrap && mon_wrap)
               now_date.year <= now_date.year + 12'd1;
         end
      end
   end
endmodule

// File: rtl/rtcal_alarm.sv
module rtcal_alarm
   import rtcal_pkg::*;
(
   input  logic                  armed,
   input  logic [NUM_FIELDS-1:0] field_en,
   input  date_t                 now_date,
   input  time_t                 now_time,
   input  date_t                 tgt_date,
   input  time_t                 tgt_time,
   output logic                  hit
);
   logic [NUM_FIELDS-1:0] eq;

   always_comb begin
      eq[0] = (now_time.sec   == tgt_time.sec);
      eq[1] = (now_time.min   == tgt_time.min);
      eq[2] = (now_time.hour  == tgt_time.hour);
      eq[3] = (now_time.dow   == tgt_time.dow);
      eq[4] = (now_date.day   == tgt_date.day);
      eq[5] = (now_date.month == tgt_date.month);
      eq[6] = (now_date.year  == tgt_date.year);
   end

   assign hit = armed && (&(eq | ~field_en));
endmodule

// File: rtl/rtcal_top.sv
module rtcal_top
   import rtcal_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter bit RAW_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int CFG_EN_LSB = 2;
   localparam int CFG_EN_MSB = CFG_EN_LSB + NUM_FIELDS - 1;

   if (DATA_W != 32) begin : g_bad_data
      $error("rtcal_top: DATA_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtcal_top: ADDR_W must be at least 4");
   end
   if (DIV_W < 1 || DIV_W > 31) begin : g_bad_div
      $error("rtcal_top: DIV_W out of range 1..31");
   end

   logic [DIV_W-1:0]      div_lim;
   logic                  run_en, running, no_leap;
   logic                  match_en, armed;
   logic [NUM_FIELDS-1:0] field_en;
   date_t                 set_date, now_date, alm_date;
   time_t                 set_time, now_time, alm_time;
   logic                  irq_en, irq_force, irq_raw;
   logic                  tick, cal_load, hit;
   logic [31:0]           wd;

   assign wd = reg_wdata[31:0];

   function automatic logic wr_at(input logic we, input logic [ADDR_W-1:0] a, input int target);
      return we && (a == ADDR_W'(target));
   endfunction

   assign cal_load = wr_at(reg_wr, reg_addr, A_CTRL) && wd[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lim   <= '0;
         run_en    <= 1'b0;
         running   <= 1'b0;
         no_leap   <= 1'b0;
         match_en  <= 1'b0;
         armed     <= 1'b0;
         field_en  <= '0;
         set_date  <= '0;
         set_time  <= '0;
         alm_date  <= '0;
         alm_time  <= '0;
         irq_en    <= 1'b0;
         irq_force <= 1'b0;
      end else begin
         running <= run_en;
         armed   <= match_en;
         if (wr_at(reg_wr, reg_addr, A_DIV))      div_lim <= wd[DIV_W-1:0];
         if (wr_at(reg_wr, reg_addr, A_CTRL)) begin
            run_en  <= wd[0];
            no_leap <= wd[3];
         end
         if (wr_at(reg_wr, reg_addr, A_SET_DATE)) set_date <= unpack_date(wd);
         if (wr_at(reg_wr, reg_addr, A_SET_TIME)) set_time <= unpack_time(wd);
         if (wr_at(reg_wr, reg_addr, A_ALM_CFG)) begin
            match_en <= wd[0];
            field_en <= wd[CFG_EN_MSB:CFG_EN_LSB];
         end
         if (wr_at(reg_wr, reg_addr, A_ALM_DATE))  alm_date  <= unpack_date(wd);
         if (wr_at(reg_wr, reg_addr, A_ALM_TIME))  alm_time  <= unpack_time(wd);
         if (wr_at(reg_wr, reg_addr, A_IRQ_EN))    irq_en    <= wd[0];
         if (wr_at(reg_wr, reg_addr, A_IRQ_FORCE)) irq_force <= wd[0];
      end
   end

   rtcal_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .clear (cal_load),
      .limit (div_lim),
      .tick  (tick)
   );

   rtcal_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (cal_load),
      .no_leap  (no_leap),
      .set_date (set_date),
      .set_time (set_time),
      .now_date (now_date),
      .now_time (now_time)
   );

   rtcal_alarm u_alm (
      .armed    (armed),
      .field_en (field_en),
      .now_date (now_date),
      .now_time (now_time),
      .tgt_date (alm_date),
      .tgt_time (alm_time),
      .hit      (hit)
   );

   if (RAW_REG) begin : g_raw_reg
      logic raw_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) raw_q <= 1'b0;
         else        raw_q <= hit;
      end
      assign irq_raw = raw_q;
   end else begin : g_raw_comb
      assign irq_raw = hit;
   end

   assign irq = (irq_raw && irq_en) || irq_force;

   always_comb begin
      logic [31:0] r;
      r = '0;
      case (int'(reg_addr))
         A_DIV:       r[DIV_W-1:0] = div_lim;
         A_CTRL:      begin r[0] = run_en; r[1] = running; r[3] = no_leap; end
         A_SET_DATE:  r = pack_date(set_date);
         A_SET_TIME:  r = pack_time(set_time);
         A_NOW_DATE:  r = pack_date(now_date);
         A_NOW_TIME:  r = pack_time(now_time);
         A_ALM_CFG:   begin r[0] = match_en; r[1] = armed; r[CFG_EN_MSB:CFG_EN_LSB] = field_en; end
         A_ALM_DATE:  r = pack_date(alm_date);
         A_ALM_TIME:  r = pack_time(alm_time);
         A_IRQ_RAW:   r[0] = irq_raw;
         A_IRQ_EN:    r[0] = irq_en;
         A_IRQ_FORCE: r[0] = irq_force;
         A_IRQ_STAT:  r[0] = irq;
         default:     r = '0;
      endcase
      reg_rdata = DATA_W'(r);
   end
endmodule

module rtcal_checker
   import rtcal_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  tick,
   input logic  running,
   input logic  run_en,
   input logic  load,
   input date_t now_date,
   input time_t now_time,
   input date_t set_date,
   input time_t set_time,
   input logic  irq_raw,
   input logic  irq_en,
   input logic  irq_force,
   input logic  irq
);
   p_tick_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !tick);

   p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> now_time.sec == (($past(now_time.sec) >= 6'd59) ? 6'd0 : $past(now_time.sec) + 6'd1));

   p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now_time.sec < 6'd59) |=> $stable(now_time.min) && $stable(now_date));

   p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (now_date == $past(set_date)) && (now_time == $past(set_time)));

   p_run_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> running);

   p_stop_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !running);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(now_time) && $stable(now_date));

   p_force_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_force |-> irq);

   p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_force && (!irq_en || !irq_raw)) |-> !irq);
endmodule

bind rtcal_top rtcal_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .running   (running),
   .run_en    (run_en),
   .load      (cal_load),
   .now_date  (now_date),
   .now_time  (now_time),
   .set_date  (set_date),
   .set_time  (set_time),
   .irq_raw   (irq_raw),
   .irq_en    (irq_en),
   .irq_force (irq_force),
   .irq       (irq)
);

// File: tb/rtcal_top_bench.sv
module rtcal_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   logic nl = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtcal_top u_rtcal_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   function automatic logic [31:0] mk_date(int y, int m, int d);
      return (32'(y) << 12) | (32'(m) << 8) | 32'(d);
   endfunction

   function automatic logic [31:0] mk_time(int w, int h, int mi, int s);
      return (32'(w) << 24) | (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
   endfunction

   function automatic bit is_leap(int y);
      return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
   endfunction

   function automatic int mdays(int m, bit lp);
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      if (m == 2) return lp ? 29 : 28;
      return 31;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 4'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic load_cal(input logic [31:0] dt, input logic [31:0] tm);
      wr(2, dt);
      wr(3, tm);
      wr(1, 32'h4 | (32'(nl) << 3));
   endtask

   task automatic step1();
      wr(1, 32'h1 | (32'(nl) << 3));
      wr(1, 32'(nl) << 3);
      settle();
   endtask

   initial begin
      repeat (200000 - 10) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(4, v); chk("R11 date after reset", v, 32'h0);
      rd(5, v); chk("R11 time after reset", v, 32'h0);
      rd(1, v); chk("R11 ctrl after reset", v, 32'h0);
      rd(12, v); chk("R11 status after reset", v, 32'h0);
      chk("R11 irq after reset", 32'(irq), 32'h0);

      // R6 load and readback
      load_cal(mk_date(2024, 3, 10), mk_time(3, 12, 30, 3));
      rd(4, v); chk("R6 loaded date", v, mk_date(2024, 3, 10));
      rd(5, v); chk("R6 loaded time", v, mk_time(3, 12, 30, 3));
      rd(1, v); chk("R6 load bit reads 0", v & 32'h4, 32'h0);

      // R7 stopped holds time
      repeat (10) @(negedge clk);
      rd(5, v); chk("R7 stopped time holds", v, mk_time(3, 12, 30, 3));

      // R1 divider timing with ratio 4
      wr(0, 32'd3);
      rd(0, v); chk("R1 divider readback", v, 32'd3);
      load_cal(mk_date(1, 1, 1), mk_time(1, 0, 0, 0));
      wr(1, 32'h1);
      rd(1, v); chk("R7 running lags enable", v & 32'h3, 32'h1);
      for (int m = 1; m <= 22; m++) begin
         @(negedge clk);
         rd(5, v);
         chk($sformatf("R1 seconds after %0d edges", m), v, mk_time(1, 0, 0, (m - 1) / 4));
         if (m == 1) begin
            rd(1, v); chk("R7 running flag set", v & 32'h3, 32'h3);
         end
      end
      wr(1, 32'h0);
      wr(0, 32'd0);
      settle();

      // R2 second sweep at a full carry boundary
      for (int s = 0; s < 60; s++) begin
         load_cal(mk_date(100, 12, 31), mk_time(7, 23, 59, s));
         step1();
         rd(5, v);
         chk("R2 second sweep time", v, (s < 59) ? mk_time(7, 23, 59, s + 1) : mk_time(1, 0, 0, 0));
         rd(4, v);
         chk("R3 second sweep date", v, (s < 59) ? mk_date(100, 12, 31) : mk_date(101, 1, 1));
      end

      // R2 hour sweep
      for (int h = 0; h < 24; h++) begin
         load_cal(mk_date(50, 6, 15), mk_time(4, h, 59, 59));
         step1();
         rd(5, v);
         chk("R2 hour sweep", v, (h < 23) ? mk_time(4, h + 1, 0, 0) : mk_time(5, 0, 0, 0));
         rd(4, v);
         chk("R3 hour sweep date", v, (h < 23) ? mk_date(50, 6, 15) : mk_date(50, 6, 16));
      end

      // R3 month ends in a common and a leap year
      for (int yi = 0; yi < 2; yi++) begin
         for (int m = 1; m <= 12; m++) begin
            int y, dw, ny, nm;
            y  = 2023 + yi;
            dw = ((m - 1) % 7) + 1;
            ny = (m == 12) ? y + 1 : y;
            nm = (m == 12) ? 1 : m + 1;
            load_cal(mk_date(y, m, mdays(m, is_leap(y))), mk_time(dw, 23, 59, 59));
            step1();
            rd(4, v); chk($sformatf("R3 month end %0d/%0d", y, m), v, mk_date(ny, nm, 1));
            rd(5, v); chk("R3 weekday advance", v, mk_time((dw == 7) ? 1 : dw + 1, 0, 0, 0));
         end
      end

      // R4 every February 28 of all years
      for (int y = 0; y < 4096; y++) begin
         load_cal(mk_date(y, 2, 28), mk_time(1, 23, 59, 59));
         step1();
         rd(4, v);
         chk($sformatf("R4 leap rule year %0d", y), v, is_leap(y) ? mk_date(y, 2, 29) : mk_date(y, 3, 1));
      end

      // R5 override: all years treated as common
      nl = 1'b1;
      for (int y = 0; y < 4096; y++) begin
         load_cal(mk_date(y, 2, 28), mk_time(1, 23, 59, 59));
         step1();
         rd(4, v);
         chk($sformatf("R5 no-leap year %0d", y), v, mk_date(y, 3, 1));
      end
      nl = 1'b0;
      wr(1, 32'h0);

      // R8 / R9 / R10 alarm and interrupt
      load_cal(mk_date(2024, 3, 10), mk_time(3, 12, 30, 3));
      wr(8, mk_time(3, 7, 0, 5));
      wr(7, mk_date(2024, 3, 10));
      wr(6, 32'h1 | 32'h4);
      settle();
      rd(6, v); chk("R8 armed flag", v & 32'h3, 32'h3);
      rd(9, v); chk("R9 raw low before match", v, 32'h0);
      step1(); step1();
      rd(9, v); chk("R9 raw high on second match", v, 32'h1);
      chk("R10 irq masked by enable", 32'(irq), 32'h0);
      wr(10, 32'h1); #1;
      chk("R10 irq with enable", 32'(irq), 32'h1);
      rd(12, v); chk("R10 status with enable", v, 32'h1);
      wr(6, 32'h1 | 32'h4 | 32'h10);
      settle();
      rd(9, v); chk("R8 hour selected mismatches", v, 32'h0);
      wr(6, 32'h4);
      settle();
      rd(6, v); chk("R8 disarmed flag", v & 32'h3, 32'h0);
      rd(9, v); chk("R8 global off no match", v, 32'h0);
      wr(6, 32'h1 | 32'h4);
      settle();
      rd(9, v); chk("R8 unselected hour ignored", v, 32'h1);
      repeat (20) @(negedge clk);
      rd(9, v); chk("R9 raw stays high while matching", v, 32'h1);
      step1();
      rd(9, v); chk("R9 raw falls after second", v, 32'h0);
      chk("R10 irq low with raw low", 32'(irq), 32'h0);
      wr(11, 32'h1); #1;
      chk("R10 force drives irq", 32'(irq), 32'h1);
      rd(12, v); chk("R10 status with force", v, 32'h1);
      wr(11, 32'h0); #1;
      chk("R10 irq after force clear", 32'(irq), 32'h0);
      wr(6, 32'h1 | 32'h1C0);
      settle();
      rd(9, v); chk("R8 date fields match", v, 32'h1);
      wr(7, mk_date(2024, 3, 11));
      settle();
      rd(9, v); chk("R8 day mismatch", v, 32'h0);
      wr(6, 32'h1 | 32'h20);
      settle();
      rd(9, v); chk("R8 weekday match", v, 32'h1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule